// File: doc/BRIEF.md
# Refresh Starvation Guard

This block sits on the chip-enable path between an access controller and a pseudo-static RAM. The memory needs short idle gaps to run its hidden refresh. A read that keeps chip enable low while the address changes faster than one read cycle can hold those gaps off indefinitely. The guard watches the upstream chip enable (active low), the write enable (active low) and the address bus. It counts how long such a starving read pattern has lasted. When the count reaches a programmable limit, set by default somewhat below the 15 µs the memory tolerates, the guard drives the final chip enable high itself for one full read cycle and signals a stall back to the controller.

Two things clear the window count. One is the upstream chip enable staying high for a full read cycle. The other is an address held steady for a full read cycle. A write cycle pauses the count and does not clear it. Every time the guard forces chip enable high, a saturating event counter advances so that a test can see it.

The controller is a two-state machine. In the state MONITOR, chip enable passes through unchanged. The transition MONITOR→FORCE is taken when the window expires. In the state FORCE, chip enable is held high and the stall is asserted. The transition FORCE→MONITOR is taken after `RC_CYC` forced cycles. All times are given in clock cycles. The defaults are 9 cycles for 70 ns and 1750 cycles for 14 µs, both at 125 MHz.

Top module: `refresh_guard`

## Requirements
- R1: While reset is asserted and right after it, `stall_o` is 0, `viol_cnt_o` is 0 and `ce_n_o` equals `ce_n_i`.
- R2: In state MONITOR, `ce_n_o` equals `ce_n_i` in the same cycle and `stall_o` is 0.
- R3: A risky cycle is one with `ce_n_i`=0 and `we_n_i`=1 and no relief. Each risky cycle advances the window by one. The cycle after the `GUARD_CYC`-th risky cycle since the last clear is the first cycle of state FORCE (MONITOR→FORCE).
- R4: When `ce_n_i` has been 1 for `RC_CYC` consecutive cycles, the window clears. A shorter high run leaves the window count unchanged.
- R5: When `addr_i` has held the same value for `RC_CYC` consecutive cycles (counting the cycle in which the value first appears), the window clears. An address that changes more often never clears it.
- R6: A cycle with `ce_n_i`=0 and `we_n_i`=0 (a write) neither advances nor clears the window.
- R7: State FORCE lasts exactly `RC_CYC` cycles, with `ce_n_o`=1 and `stall_o`=1, and then returns to MONITOR. The window restarts from zero when forcing begins, so an unbroken starving pattern is forced once every `GUARD_CYC`+`RC_CYC` cycles.
- R8: `viol_cnt_o` rises by exactly one for each entry to FORCE, and the new value is visible in the first FORCE cycle. It changes at no other time.
- R9: `viol_cnt_o` (`CNT_W` bits, 16 by default) saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Memory address from the controller |
| ce_n_i | input | 1 | Upstream chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| ce_n_o | output | 1 | Final chip enable to the memory, active low |
| stall_o | output | 1 | High while the guard is forcing chip enable high |
| viol_cnt_o | output | CNT_W | Saturating count of forced insertions |

## Verification
On every cycle, the assertions check these relations: the pass-through of chip enable outside FORCE, that chip enable is high during every stall cycle, the exact length of each stall, that the counter steps only when a stall begins, and that the counter stays at all ones once saturated. The timing of the MONITOR→FORCE transition depends on the history of the three inputs. Only the bench's scenarios can show it. These scenarios sweep address-change periods, chip-enable-high gap lengths and write-burst lengths, and compare each forcing instant with a value computed from the window limit.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
    typedef enum logic {
        ST_MONITOR = 1'b0,
        ST_FORCE   = 1'b1
    } rfg_state_e;
endpackage

// File: rtl/refresh_guard_activity.sv
// Tracks run lengths of a steady address and of upstream chip enable high.
// relief_o is set in the cycle where either run reaches a full read cycle.
module refresh_guard_activity #(
    parameter int ADDR_W = 20,
    parameter int RC_CYC = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    output logic              relief_o
);
    localparam int RC_W = $clog2(RC_CYC + 1);
    localparam logic [RC_W-1:0] RC_MAX = RC_W'(RC_CYC);

    logic [ADDR_W-1:0] addr_q;
    logic [RC_W-1:0]   hold_q, hold_d;
    logic [RC_W-1:0]   high_q, high_d;

    always_comb begin
        if (addr_i != addr_q)
            hold_d = RC_W'(1);
        else if (hold_q == RC_MAX)
            hold_d = RC_MAX;
        else
            hold_d = hold_q + RC_W'(1);

        if (!ce_n_i)
            high_d = '0;
        else if (high_q == RC_MAX)
            high_d = RC_MAX;
        else
            high_d = high_q + RC_W'(1);

        relief_o = (hold_d == RC_MAX) || (high_d == RC_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hold_q <= '0;
            high_q <= '0;
        end else begin
            addr_q <= addr_i;
            hold_q <= hold_d;
            high_q <= high_d;
        end
    end
endmodule

// File: rtl/refresh_guard_window.sv
// Counts risky cycles since the last clear; expire_o marks the last one.
module refresh_guard_window #(
    parameter int GUARD_CYC = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clear_i,
    output logic expire_o
);
    localparam int WIN_W = (GUARD_CYC > 2) ? $clog2(GUARD_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(GUARD_CYC - 1);

    logic [WIN_W-1:0] win_q;

    assign expire_o = step_i && !clear_i && (win_q == WIN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_q <= '0;
        else if (clear_i || expire_o)
            win_q <= '0;
        else if (step_i)
            win_q <= win_q + WIN_W'(1);
    end
endmodule

// File: rtl/refresh_guard_evcnt.sv
// Saturating event counter.
module refresh_guard_evcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (inc_i && (count_o != {CNT_W{1'b1}}))
            count_o <= count_o + CNT_W'(1);
    end
endmodule

// File: rtl/refresh_guard.sv
module refresh_guard
    import rfg_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int RC_CYC    = 9,
    parameter int GUARD_CYC = 1750,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    output logic              ce_n_o,
    output logic              stall_o,
    output logic [CNT_W-1:0]  viol_cnt_o
);
    localparam int RC_W = $clog2(RC_CYC + 1);
    localparam logic [RC_W-1:0] FC_LAST = RC_W'(RC_CYC - 1);

    rfg_state_e      state_q, state_d;
    logic [RC_W-1:0] fcnt_q;
    logic            relief, step, clear, expire;

    refresh_guard_activity #(.ADDR_W(ADDR_W), .RC_CYC(RC_CYC)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .ce_n_i   (ce_n_i),
        .relief_o (relief)
    );

    assign step  = (state_q == ST_MONITOR) && !ce_n_i && we_n_i;
    assign clear = relief || (state_q == ST_FORCE);

    refresh_guard_window #(.GUARD_CYC(GUARD_CYC)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .clear_i  (clear),
        .expire_o (expire)
    );

    refresh_guard_evcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (expire),
        .count_o (viol_cnt_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MONITOR: if (expire) state_d = ST_FORCE;
            ST_FORCE:   if (fcnt_q == FC_LAST) state_d = ST_MONITOR;
            default:    state_d = ST_MONITOR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MONITOR;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            fcnt_q  <= (state_q == ST_FORCE && state_d == ST_FORCE)
                       ? fcnt_q + RC_W'(1) : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_MONITOR: begin
                ce_n_o  = ce_n_i;
                stall_o = 1'b0;
            end
            ST_FORCE: begin
                ce_n_o  = 1'b1;
                stall_o = 1'b1;
            end
            default: begin
                ce_n_o  = ce_n_i;
                stall_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/refresh_guard_chk.sv
module refresh_guard_chk #(
    parameter int RC_CYC = 9,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n_i,
    input logic             ce_n_o,
    input logic             stall_o,
    input logic [CNT_W-1:0] viol_cnt_o
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= 0;
        else
            run_q <= stall_o ? run_q + 1 : 0;
    end

    // R7
    force_ce_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> ce_n_o);

    // R2
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> (ce_n_o == ce_n_i));

    // R7
    force_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (run_q < RC_CYC));

    // R7
    force_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> (run_q == RC_CYC));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> ((viol_cnt_o == $past(viol_cnt_o) + CNT_W'(1))
                            || (&$past(viol_cnt_o))));

    // R8
    cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(stall_o) |-> $stable(viol_cnt_o));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(viol_cnt_o)) |-> (&viol_cnt_o));
endmodule

bind refresh_guard refresh_guard_chk #(.RC_CYC(RC_CYC), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n_i     (ce_n_i),
    .ce_n_o     (ce_n_o),
    .stall_o    (stall_o),
    .viol_cnt_o (viol_cnt_o)
);

// File: tb/refresh_guard_tb.sv
module refresh_guard_tb;
    localparam int AW = 8;
    localparam int RC = 3;
    localparam int GD = 20;
    localparam int CW = 4;
    localparam int PER = GD + RC;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          ce_n_o, stall_o;
    logic [CW-1:0] cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    refresh_guard #(.ADDR_W(AW), .RC_CYC(RC), .GUARD_CYC(GD), .CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .ce_n_i     (ce_n),
        .we_n_i     (we_n),
        .ce_n_o     (ce_n_o),
        .stall_o    (stall_o),
        .viol_cnt_o (cnt)
    );

    task automatic apply(input logic c, input logic w, input logic [AW-1:0] a,
                         input bit frc, input int ecnt, input string tag);
        logic ece;
        @(negedge clk);
        ce_n = c; we_n = w; addr = a;
        #2;
        ece = frc ? 1'b1 : c;
        checks++;
        if (ce_n_o !== ece || stall_o !== frc || cnt !== CW'(ecnt)) begin
            fails++;
            $display("FAIL %s: ce_n_o=%0b stall=%0b cnt=%0d expected ce_n_o=%0b stall=%0b cnt=%0d",
                     tag, ce_n_o, stall_o, cnt, ece, frc, ecnt);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        // R1: pass-through during reset
        apply(1'b0, 1'b1, '0, 1'b0, 0, "R1 in reset");
        apply(1'b1, 1'b1, '0, 1'b0, 0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b1, 1'b1, '0, 1'b0, 0, "R1 after reset");
        apply(1'b1, 1'b1, '0, 1'b0, 0, "R1 after reset");
    endtask

    function automatic int nforce(input int t);
        int n;
        n = (t >= GD) ? (t - GD) / PER + 1 : 0;
        return (n > CMAX) ? CMAX : n;
    endfunction

    initial begin
        // R3 R7 R8: unbroken starving reads, address period below a read cycle
        for (int p = 1; p < RC; p++) begin
            do_reset();
            for (int t = 0; t < 3 * PER + 4; t++)
                apply(1'b0, 1'b1, AW'(t / p + 1), (t % PER) >= GD, nforce(t),
                      "R3/R7/R8 periodic forcing");
        end
        // R5: address held a full read cycle never starves
        for (int p = RC; p <= RC + 1; p++) begin
            do_reset();
            for (int t = 0; t < 3 * PER; t++)
                apply(1'b0, 1'b1, AW'(t / p + 1), 1'b0, 0, "R5 steady address");
        end
        // R4 R2: chip enable high gaps of varying length
        for (int h = 1; h <= RC + 1; h++) begin
            int f;
            f = 15 + h + ((h >= RC) ? GD : GD - 15);
            do_reset();
            for (int t = 0; t < f + RC + 3; t++) begin
                bit hi;
                hi = (t >= 15) && (t < 15 + h);
                apply(hi, 1'b1, AW'(t + 1), (t >= f) && (t < f + RC), (t >= f) ? 1 : 0,
                      (h >= RC) ? "R4 long gap clears" : "R4 short gap holds");
            end
        end
        // R6: write bursts pause the window
        for (int w = 1; w <= RC + 1; w++) begin
            int f;
            f = 15 + w + (GD - 15);
            do_reset();
            for (int t = 0; t < f + RC + 3; t++) begin
                bit wr;
                wr = (t >= 15) && (t < 15 + w);
                apply(1'b0, !wr, AW'(t + 1), (t >= f) && (t < f + RC), (t >= f) ? 1 : 0,
                      "R6 write pauses window");
            end
        end
        // R9: counter saturation
        do_reset();
        for (int t = 0; t < (CMAX + 3) * PER; t++)
            apply(1'b0, 1'b1, AW'(t + 1), (t % PER) >= GD, nforce(t), "R9 saturation");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule